// File: doc/BRIEF.md
# Bus Timeout Error Capture Register

This block keeps the 32-bit error status word of a processor-to-memory interconnect. A register-space access decoder strobes it whenever a read or a write goes to an address that no responder claims, or that a responder never answers. The block keeps the first such timeout together with the context of the access: whether it was a virtual reference, and the processor mode at that time. It then holds that record until the machine-check handler has serviced it.

If another timeout arrives while the first one is still unserviced, the block sets a sticky lost-error flag and keeps the first context. A read timeout raises a machine-check request for one cycle. A write timeout raises a memory-error interrupt request for one cycle instead. Software cannot write the status word. Next to it, the block also holds a one-bit cache-disable control register, written from a data bus.

Top module: `bus_tmo_capture`

## Requirements
- R1: While reset is low, and after it is released, `err_reg_o` reads 32'h0010_0000 (only the enable bit, bit 20, set), and `mchk_req_o`, `memerr_irq_o` and `cdis_o` are 0.
- R2: A timeout seen at a clock edge while the pending bit (bit 3) is clear sets bit 3 after that edge. It also loads bit 18 with the virtual-reference flag, and bits 17:16 with `cur_mode_i` if the access was virtual, or with 0 if it was not.
- R3: A timeout seen while bit 3 is set (and no clear arrives in the same cycle) sets the lost-error bit (bit 1) and leaves bits 18:16 unchanged. Bit 1 stays set until reset.
- R4: A read timeout (`tmo_wr_i`=0) drives `mchk_req_o` high for exactly the one cycle after the edge that saw it. A write timeout (`tmo_wr_i`=1) does the same on `memerr_irq_o`. The two requests are never high together.
- R5: A `mchk_done_i` pulse with no timeout clears bit 3 after the edge. Without a clear, bit 3 stays set.
- R6: When `cdis_we_i` is high, `cdis_o` takes bit 0 of `cdis_wdata_i`. Bits 31:1 of the data have no effect. Without a write, `cdis_o` holds its value.
- R7: A timeout and `mchk_done_i` in the same cycle count as a first error: bit 3 is set, the context is loaded as in R2, and bit 1 is not set by that event.
- R8: Bits 0, 2, 4, 8 to 11 and 19, and all bits not named above, always read 0. Bit 20 always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmo_i | input | 1 | Timeout strobe from the register-space decoder |
| tmo_wr_i | input | 1 | Access direction of the timed-out access, 1 = write |
| tmo_virt_i | input | 1 | Timed-out access was a virtual reference |
| cur_mode_i | input | 2 | Current processor mode |
| mchk_done_i | input | 1 | Machine-check servicing complete, clears pending |
| cdis_we_i | input | 1 | Write strobe for the cache-disable register |
| cdis_wdata_i | input | 32 | Write data for the cache-disable register |
| err_reg_o | output | 32 | Error status word |
| mchk_req_o | output | 1 | Machine-check request, read timeout |
| memerr_irq_o | output | 1 | Memory-error interrupt request, write timeout |
| cdis_o | output | 1 | Cache-disable control bit |

## Verification
The bench sweeps every combination of timeout, direction, virtual flag, mode, clear and cache-disable write twice, in two different orders, so that each combination meets both a pending and an idle register. The collision of a timeout with a clear is the main corner case. A design that applied the clear last would drop the new error, and one that tested the old pending flag would raise a false lost-error bit. A second timeout on a pending error must not disturb the captured mode. A design that overwrote it would report the wrong access context to the handler. Non-virtual first errors must zero the mode field, and cache-disable writes with odd upper data bits must change only bit 0.

// File: rtl/bte_pkg.sv
package bte_pkg;
  localparam int unsigned ERR_W    = 32;
  localparam int unsigned MODE_W   = 2;
  // field positions are decoded by the machine-check handler
  localparam int unsigned BIT_LOST = 1;
  localparam int unsigned BIT_PEND = 3;
  localparam int unsigned MODE_LSB = 16;
  localparam int unsigned BIT_VREF = MODE_LSB + MODE_W;
  localparam int unsigned BIT_EN   = 20;
  localparam int unsigned NREQ     = 2;

  typedef struct packed {
    logic              vref;
    logic [MODE_W-1:0] mode;
  } acc_ctx_t;

  typedef enum logic [0:0] {
    REQ_MCHK   = 1'b0,
    REQ_MEMERR = 1'b1
  } req_kind_e;
endpackage

// File: rtl/bte_status.sv
module bte_status
  import bte_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmo_i,
  input  logic              virt_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              clr_i,
  output logic              pend_o,
  output logic              lost_o,
  output acc_ctx_t          ctx_o
);
  logic     pend_q, lost_q;
  acc_ctx_t ctx_q;
  logic     pend_eff, first_err, again_err;

  // clear is applied before the new capture
  assign pend_eff  = pend_q & ~clr_i;
  assign first_err = tmo_i & ~pend_eff;
  assign again_err = tmo_i & pend_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lost_q <= 1'b0;
      ctx_q  <= '0;
    end else begin
      pend_q <= first_err | pend_eff;
      lost_q <= lost_q | again_err;
      if (first_err) begin
        ctx_q.vref <= virt_i;
        ctx_q.mode <= virt_i ? mode_i : '0;
      end
    end
  end

  assign pend_o = pend_q;
  assign lost_o = lost_q;
  assign ctx_o  = ctx_q;

  AST_TMO_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> pend_q); // R2
  AST_LOST_CTX_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && pend_q && !clr_i) |=> ($stable(ctx_q) && lost_q)); // R3
  AST_LOST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |=> lost_q); // R3
  AST_CLR_DROPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !tmo_i) |=> !pend_q); // R5
  AST_COLLIDE_IS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && clr_i && !lost_q) |=> !lost_q); // R7
endmodule

// File: rtl/bte_req_gen.sv
module bte_req_gen
  import bte_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tmo_i,
  input  logic            wr_i,
  output logic [NREQ-1:0] req_o
);
  logic [NREQ-1:0] hit, req_q;

  for (genvar k = 0; k < NREQ; k++) begin : g_kind
    assign hit[k] = tmo_i & (wr_i == 1'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= hit;
  end

  assign req_o = req_q;

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_q)); // R4
  AST_REQ_FOLLOWS_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> ($countones(req_q) == 1)); // R4
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmo_i |=> (req_q == '0)); // R4
endmodule

// File: rtl/bte_cdis_reg.sv
module bte_cdis_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              cdis_o
);
  logic cdis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cdis_q <= 1'b0;
    else if (we_i) cdis_q <= wdata_i[0];
  end

  assign cdis_o = cdis_q;

  AST_CDIS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cdis_q)); // R6
  AST_CDIS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cdis_q == $past(wdata_i[0]))); // R6
endmodule

// File: rtl/bus_tmo_capture.sv
module bus_tmo_capture
  import bte_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmo_i,
  input  logic              tmo_wr_i,
  input  logic              tmo_virt_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic              mchk_done_i,
  input  logic              cdis_we_i,
  input  logic [DATA_W-1:0] cdis_wdata_i,
  output logic [ERR_W-1:0]  err_reg_o,
  output logic              mchk_req_o,
  output logic              memerr_irq_o,
  output logic              cdis_o
);
  logic            pend, lost;
  acc_ctx_t        ctx;
  logic [NREQ-1:0] req;

  bte_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tmo_i  (tmo_i),
    .virt_i (tmo_virt_i),
    .mode_i (cur_mode_i),
    .clr_i  (mchk_done_i),
    .pend_o (pend),
    .lost_o (lost),
    .ctx_o  (ctx)
  );

  bte_req_gen u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tmo_i  (tmo_i),
    .wr_i   (tmo_wr_i),
    .req_o  (req)
  );

  bte_cdis_reg #(.DATA_W(DATA_W)) u_cdis (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cdis_we_i),
    .wdata_i (cdis_wdata_i),
    .cdis_o  (cdis_o)
  );

  // sources of the other status bits lie outside this block; they read zero
  always_comb begin
    err_reg_o                      = '0;
    err_reg_o[BIT_LOST]            = lost;
    err_reg_o[BIT_PEND]            = pend;
    err_reg_o[MODE_LSB +: MODE_W]  = ctx.mode;
    err_reg_o[BIT_VREF]            = ctx.vref;
    err_reg_o[BIT_EN]              = 1'b1;
  end

  assign mchk_req_o   = req[REQ_MCHK];
  assign memerr_irq_o = req[REQ_MEMERR];

  AST_LOST_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_reg_o[BIT_LOST]) |-> err_reg_o[BIT_PEND]); // R3
  AST_MODE_ZERO_PHYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_reg_o[BIT_VREF] |-> (err_reg_o[MODE_LSB +: MODE_W] == '0)); // R2
endmodule

// File: tb/sim_bus_tmo_capture.sv
module sim_bus_tmo_capture;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] USED_MASK = 32'h0007_000A;
  localparam logic [31:0] CONST_VAL = 32'h0010_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tmo_i = 1'b0, tmo_wr_i = 1'b0, tmo_virt_i = 1'b0;
  logic [1:0]  cur_mode_i = 2'd0;
  logic        mchk_done_i = 1'b0, cdis_we_i = 1'b0;
  logic [31:0] cdis_wdata_i = '0;
  logic [31:0] err_reg_o;
  logic        mchk_req_o, memerr_irq_o, cdis_o;

  int n_chk = 0, n_fail = 0;
  logic m_pend = 0, m_lost = 0, m_vref = 0, m_mreq = 0, m_ereq = 0, m_cdis = 0;
  logic [1:0] m_mode = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_tmo_capture u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tmo_i(tmo_i), .tmo_wr_i(tmo_wr_i),
    .tmo_virt_i(tmo_virt_i), .cur_mode_i(cur_mode_i), .mchk_done_i(mchk_done_i),
    .cdis_we_i(cdis_we_i), .cdis_wdata_i(cdis_wdata_i), .err_reg_o(err_reg_o),
    .mchk_req_o(mchk_req_o), .memerr_irq_o(memerr_irq_o), .cdis_o(cdis_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R5", "pending bit", 32'(err_reg_o[3]), 32'(m_pend));
    chk("R3", "lost bit", 32'(err_reg_o[1]), 32'(m_lost));
    chk("R2", "context", 32'(err_reg_o[18:16]), 32'({m_vref, m_mode}));
    chk("R8", "fixed bits", err_reg_o & ~USED_MASK, CONST_VAL);
    chk("R4", "mchk req", 32'(mchk_req_o), 32'(m_mreq));
    chk("R4", "memerr irq", 32'(memerr_irq_o), 32'(m_ereq));
    chk("R6", "cache disable", 32'(cdis_o), 32'(m_cdis));
  endtask

  // called just after a falling edge; checks the result one cycle later
  task automatic step(input logic t, input logic w, input logic v,
                      input logic [1:0] m, input logic c, input logic we,
                      input logic [31:0] d);
    logic pe;
    tmo_i = t; tmo_wr_i = w; tmo_virt_i = v; cur_mode_i = m;
    mchk_done_i = c; cdis_we_i = we; cdis_wdata_i = d;
    pe = m_pend & ~c;
    if (t && !pe) begin
      m_vref = v;
      m_mode = v ? m : 2'd0;
    end
    m_lost = m_lost | (t & pe);
    m_pend = t | pe;
    m_mreq = t & ~w;
    m_ereq = t & w;
    if (we) m_cdis = d[0];
    @(negedge clk_i);
    check_all();
  endtask

  task automatic do_reset();
    tmo_i = 0; mchk_done_i = 0; cdis_we_i = 0;
    rst_ni = 1'b0;
    m_pend = 0; m_lost = 0; m_vref = 0; m_mode = 0; m_mreq = 0; m_ereq = 0; m_cdis = 0;
    @(negedge clk_i);
    chk("R1", "reset word", err_reg_o, 32'h0010_0000);
    chk("R1", "reset mchk", 32'(mchk_req_o), 0);
    chk("R1", "reset memerr", 32'(memerr_irq_o), 0);
    chk("R1", "reset cdis", 32'(cdis_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "word after release", err_reg_o, 32'h0010_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    do_reset();
    // two full sweeps of the 8 input bits in different orders
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0]  v;
        logic [31:0] d;
        v = (pass == 0) ? 8'(i * 37) : 8'(i * 101 + 55);
        d = 32'(i * 32'h9E37_79B9) ^ 32'hAAAA_5554;
        d[0] = v[7];
        step(v[0], v[1], v[2], v[4:3], v[5], v[6], d);
      end
    end
    step(0, 0, 0, 2'd0, 0, 0, 32'h0);

    // directed: collision of timeout and clear, then lost error
    do_reset();
    step(1, 0, 1, 2'd2, 0, 0, 32'h0);           // R2 first virtual read error
    chk("R2", "mode captured", 32'(err_reg_o[17:16]), 2);
    step(1, 1, 1, 2'd1, 1, 0, 32'h0);           // R7 clear with new error
    chk("R7", "collision lost", 32'(err_reg_o[1]), 0);
    chk("R7", "collision pend", 32'(err_reg_o[3]), 1);
    chk("R7", "collision mode", 32'(err_reg_o[17:16]), 1);
    step(1, 0, 0, 2'd3, 0, 0, 32'h0);           // R3 second error
    chk("R3", "second error lost", 32'(err_reg_o[1]), 1);
    chk("R3", "second error ctx", 32'(err_reg_o[18:16]), 32'h5);
    step(0, 0, 0, 2'd0, 1, 0, 32'h0);           // R5 clear
    chk("R5", "cleared pend", 32'(err_reg_o[3]), 0);
    chk("R3", "lost survives clear", 32'(err_reg_o[1]), 1);
    step(1, 1, 0, 2'd3, 0, 0, 32'h0);           // R2 physical first error
    chk("R2", "physical ctx", 32'(err_reg_o[18:16]), 0);
    step(0, 0, 0, 2'd0, 0, 1, 32'hFFFF_FFFE);   // R6 upper bits ignored
    chk("R6", "odd upper bits", 32'(cdis_o), 0);
    step(0, 0, 0, 2'd0, 0, 1, 32'h0000_0001);
    chk("R6", "bit0 set", 32'(cdis_o), 1);
    step(0, 0, 0, 2'd0, 0, 0, 32'h0);
    chk("R6", "hold", 32'(cdis_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule